// File: doc/BRIEF.md
# Slice Wide-Multiplexer Tree

This block builds a 16:1 multiplexer the way a logic slice does. It does not use one flat selector. Four small lookup-table stages each act as a 4:1 multiplexer, and they all share the two low select bits. Two dedicated 2:1 stages then merge neighbouring table results into 8:1 functions. A final 2:1 stage merges those two into the 16:1 result. All three levels are visible at the ports, so a user can tap a 4:1, 8:1 or 16:1 function from the same tree.

The sixteen data words come in as one packed bus. Word `i` occupies bits `[i*DATA_W +: DATA_W]`. A 4-bit select picks among them. The whole path is combinational and has no registers, clock or reset. A small decode stage splits the select into the strobes each level uses. The datapath stage holds the tables and the dedicated stages.

Top module: `slice_mux_tree`

## Requirements
- R1: Table output k (word k of `lutOut`, k = 0..3) equals data word `4*k + sel[1:0]`.
- R2: Lower pair output (`pairOut` word 0) equals table 0 when `sel[2]`=0 and table 1 when `sel[2]`=1.
- R3: Upper pair output (`pairOut` word 1) equals table 2 when `sel[2]`=0 and table 3 when `sel[2]`=1.
- R4: `wideOut` equals the lower pair output when `sel[3]`=0 and the upper pair output when `sel[3]`=1, so that it equals data word `sel`.
- R5: A select of 0 returns data word 0 on `wideOut`.
- R6: Every output reflects the current inputs within the same cycle, because the block holds no state.
- R7: Changing any data word other than word `sel` leaves `wideOut` unchanged.
- R8: Each bit lane of a data word is routed on its own, with no mixing between lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 16*DATA_W | Sixteen packed data words, word i at bits [i*DATA_W +: DATA_W] |
| sel | input | 4 | Select: [1:0] to the tables, [2] to the pair stages, [3] to the final stage |
| lutOut | output | 4*DATA_W | Four 4:1 table results, table k at word k |
| pairOut | output | 2*DATA_W | Two 8:1 results, lower at word 0 |
| wideOut | output | DATA_W | 16:1 result |

## Verification
All results are due zero cycles after a stimulus, because no register lies on any path. The driver applies each new input set just after a rising edge and queues the expected values. The monitor compares them at the following falling edge, half a period later, once the combinational logic has settled. The bench never samples at the edge where the inputs change, so each expected item lines up with exactly one applied input set.

// File: rtl/muxtree_pkg.sv
package muxtree_pkg;
  localparam int TABLE_CNT = 4;
  localparam int TABLE_WAYS = 4;
  localparam int PAIR_CNT = TABLE_CNT / 2;
  localparam int WORD_CNT = TABLE_CNT * TABLE_WAYS;
  localparam int SEL_W = $clog2(WORD_CNT);
  localparam int TSEL_W = $clog2(TABLE_WAYS);

  typedef struct packed {
    logic [TSEL_W-1:0] tableSel;
    logic pairSel;
    logic wideSel;
  } selStrobes_t;
endpackage

// File: rtl/muxtree_ctrl.sv
module muxtree_ctrl
  import muxtree_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output selStrobes_t      strobes
);
  always_comb begin
    strobes.tableSel = sel[TSEL_W-1:0];
    strobes.pairSel  = sel[TSEL_W];
    strobes.wideSel  = sel[TSEL_W+1];
  end
endmodule

// File: rtl/muxtree_lut4.sv
module muxtree_lut4 #(
  parameter int DATA_W = 1,
  parameter int WAYS = 4,
  localparam int SW = $clog2(WAYS)
) (
  input  logic [WAYS*DATA_W-1:0] ways,
  input  logic [SW-1:0]          pick,
  output logic [DATA_W-1:0]      result
);
  // One table configured as a small selector: two inputs pick, rest are data.
  always_comb begin
    result = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (pick == SW'(w)) result = ways[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/muxtree_dp.sv
module muxtree_dp
  import muxtree_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic [WORD_CNT*DATA_W-1:0]  dataIn,
  input  selStrobes_t                 strobes,
  output logic [TABLE_CNT*DATA_W-1:0] lutOut,
  output logic [PAIR_CNT*DATA_W-1:0]  pairOut,
  output logic [DATA_W-1:0]           wideOut
);
  localparam int GROUP_W = TABLE_WAYS * DATA_W;

  genvar t;
  generate
    for (t = 0; t < TABLE_CNT; t++) begin : gTable
      muxtree_lut4 #(.DATA_W(DATA_W), .WAYS(TABLE_WAYS)) uTable (
        .ways  (dataIn[t*GROUP_W +: GROUP_W]),
        .pick  (strobes.tableSel),
        .result(lutOut[t*DATA_W +: DATA_W])
      );
    end
  endgenerate

  // Dedicated second-level stages: tables 2p and 2p+1 feed pair p.
  genvar p;
  generate
    for (p = 0; p < PAIR_CNT; p++) begin : gPair
      assign pairOut[p*DATA_W +: DATA_W] = strobes.pairSel
          ? lutOut[(2*p+1)*DATA_W +: DATA_W]
          : lutOut[(2*p)*DATA_W +: DATA_W];
    end
  endgenerate

  // Dedicated third-level stage.
  assign wideOut = strobes.wideSel ? pairOut[DATA_W +: DATA_W] : pairOut[0 +: DATA_W];
endmodule

// File: rtl/slice_mux_tree.sv
module slice_mux_tree #(
  parameter int DATA_W = 1
) (
  input  logic [16*DATA_W-1:0] dataIn,
  input  logic [3:0]           sel,
  output logic [4*DATA_W-1:0]  lutOut,
  output logic [2*DATA_W-1:0]  pairOut,
  output logic [DATA_W-1:0]    wideOut
);
  import muxtree_pkg::*;

  selStrobes_t strobes;

  muxtree_ctrl uCtrl (
    .sel    (sel),
    .strobes(strobes)
  );

  muxtree_dp #(.DATA_W(DATA_W)) uDp (
    .dataIn (dataIn),
    .strobes(strobes),
    .lutOut (lutOut),
    .pairOut(pairOut),
    .wideOut(wideOut)
  );
endmodule

// File: rtl/slice_mux_tree_chk.sv
module slice_mux_tree_chk #(
  parameter int DATA_W = 1
) (
  input logic [16*DATA_W-1:0] dataIn,
  input logic [3:0]           sel,
  input logic [4*DATA_W-1:0]  lutOut,
  input logic [2*DATA_W-1:0]  pairOut,
  input logic [DATA_W-1:0]    wideOut
);
  logic known;
  assign known = !$isunknown({dataIn, sel});

  always_comb begin
    if (known) begin
      for (int k = 0; k < 4; k++) begin
        a_r1_table_pick: assert (lutOut[k*DATA_W +: DATA_W] ==
                                 dataIn[(4*k + int'(sel[1:0]))*DATA_W +: DATA_W]);
      end
      a_r2_lower_pair: assert (pairOut[0 +: DATA_W] ==
                               lutOut[int'(sel[2])*DATA_W +: DATA_W]);
      a_r3_upper_pair: assert (pairOut[DATA_W +: DATA_W] ==
                               lutOut[(2 + int'(sel[2]))*DATA_W +: DATA_W]);
      a_r4_wide_index: assert (wideOut == dataIn[int'(sel)*DATA_W +: DATA_W]);
      if (sel == 4'd0) begin
        a_r5_zero_select: assert (wideOut == dataIn[0 +: DATA_W]);
      end
    end
  end
endmodule

bind slice_mux_tree slice_mux_tree_chk #(.DATA_W(DATA_W)) uChk (
  .dataIn (dataIn),
  .sel    (sel),
  .lutOut (lutOut),
  .pairOut(pairOut),
  .wideOut(wideOut)
);

// File: tb/tb_slice_mux_tree.sv
module tb_slice_mux_tree;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [16*W-1:0] dataIn = '0;
  logic [3:0] sel = '0;
  logic [4*W-1:0] lutOut;
  logic [2*W-1:0] pairOut;
  logic [W-1:0] wideOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  slice_mux_tree #(.DATA_W(W)) dut (
    .dataIn(dataIn), .sel(sel), .lutOut(lutOut), .pairOut(pairOut), .wideOut(wideOut)
  );

  typedef struct {
    logic [4*W-1:0] lut;
    logic [2*W-1:0] pair;
    logic [W-1:0]   wide;
    string          tag;
  } item_t;

  item_t expQ[$];

  function automatic logic [W-1:0] word(input logic [16*W-1:0] d, input int i);
    return d[i*W +: W];
  endfunction

  task automatic drive(input logic [16*W-1:0] d, input logic [3:0] s, input string tag);
    item_t it;
    @(posedge clk);
    dataIn <= d;
    sel <= s;
    for (int k = 0; k < 4; k++) it.lut[k*W +: W] = word(d, 4*k + int'(s[1:0]));
    it.pair[0 +: W] = word(d, int'(s[2]) * 4 + int'(s[1:0]));
    it.pair[W +: W] = word(d, 8 + int'(s[2]) * 4 + int'(s[1:0]));
    it.wide = word(d, int'(s));
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: outputs are combinational, due half a cycle after the drive edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      cmp({"R1 ", it.tag}, 64'(lutOut), 64'(it.lut));
      cmp({"R2/R3 ", it.tag}, 64'(pairOut), 64'(it.pair));
      cmp({"R4 ", it.tag}, 64'(wideOut), 64'(it.wide));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [16*W-1:0] ramp;
    logic [16*W-1:0] alt;
    for (int i = 0; i < 16; i++) ramp[i*W +: W] = W'(i);
    // Reset-phase check: all-zero inputs give all-zero outputs (R6).
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R6 idle", 64'({lutOut, pairOut, wideOut}), 64'(0));

    // R4/R5: every select over a ramp; select 0 gives word 0.
    for (int s = 0; s < 16; s++) drive(ramp, 4'(s), "ramp");
    drive(ramp, 4'd0, "R5 select zero");

    // R8: per-lane one-hot across all words and selects.
    for (int b = 0; b < W; b++) begin
      for (int s = 0; s < 16; s++) begin
        logic [16*W-1:0] oh;
        oh = '0;
        oh[s*W + b] = 1'b1;
        drive(oh, 4'(s), "R8 lane onehot");
      end
    end

    // R7: selected word fixed, all others toggled.
    for (int s = 0; s < 16; s++) begin
      alt = {16{4'hA}};
      alt[s*W +: W] = 4'h5;
      drive(alt, 4'(s), "R7 others A");
      alt = {16{4'h3}};
      alt[s*W +: W] = 4'h5;
      drive(alt, 4'(s), "R7 others 3");
    end

    // R6: data changes with select held; outputs follow in the same cycle.
    for (int n = 0; n < 24; n++) begin
      logic [16*W-1:0] d;
      for (int i = 0; i < 16; i++) d[i*W +: W] = W'((i * 7 + n * 5 + 3) % 16);
      drive(d, 4'((n * 3) % 16), "R6 mixed");
    end

    @(posedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule